// File: doc/BRIEF.md
# Masked Priority Interrupt Vector Controller

This controller gathers level-sensitive interrupt requests from up to 32 peripheral sources, holds them in a pending register and masks them with a mask register that software can write. It drives one interrupt line to the processor core. Its vector word tells the interrupt handler which source to serve. The vector carries the code of the winning source among those that are both pending and unmasked. Priority is fixed: the lowest source index wins. The code of source `i` is `i+1`.

A handler can mask a source in the same cycle that the source is asserting the core request. The handler then still takes the interrupt, but no source is left to name. For this case the controller loads a dedicated error code, all zeros, into the vector. No source uses that code and no mask bit can suppress it. As a result, every vector read that follows a taken request returns a defined value.

Software reaches three word registers over a simple register bus with combinational read data. Address 0 holds the mask (read/write). Address 1 holds the pending bits (read-only). Address 2 holds the vector (read-only). Source `i` uses bit `i` of both the mask word and the pending word, whatever its priority.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the mask, pending and vector registers all read zero and `irq_o` is low, so every source starts masked.
- R2: A write to address 0 updates the mask on that clock edge. Source bits 10, 15 and 31 are unimplemented: they ignore writes and read as zero, so writing all ones reads back 0x7FFF7BFF.
- R3: Pending bit `i` takes the level of `src_req[i]` one clock after it is sampled. It stays set as long as the request is held. This means a source that ORs several events stays pending until its last event clears. The unimplemented sources never become pending.
- R4: `irq_o` is high in exactly those cycles in which at least one registered pending bit has its mask bit set.
- R5: One clock after a change in the set of unmasked pending sources, the vector loads code `i+1` for the lowest index `i` in that set. A read of address 2 returns the code in bits 31:24 and zeros in bits 23:0.
- R6: If `irq_o` was high in the previous cycle and no unmasked source is pending now, the vector loads the error code 0x00 on the next clock. The mask has no effect on this, and it applies whether the mask was cleared or the request was dropped.
- R7: While `irq_o` is low and was low in the previous cycle, the vector keeps its value, even if masked sources become pending.
- R8: Writes to addresses 1, 2 and 3 change no register. Address 3 reads as zero, and `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Level request per source |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
A mask write from the handler and the vector update can land on the same clock edge. This happens when the handler clears the mask bit of the only active source while that source is still asserting `irq_o`. The bench provokes this by writing a zero mask while a single unmasked source is pending. It then checks that `irq_o` falls immediately and that one clock later the vector reads the error code rather than the stale source code. The bench also repeats the mask write with a second unmasked source still pending, and checks that the vector then names that source and not the error code.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int DATA_W = 32;
    localparam int CODE_W = 8;
    localparam int ADDR_W = 2;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t ERR_CODE = '0;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK = 2'd0,
        RA_PEND = 2'd1,
        RA_VEC  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic  hit;
        code_t code;
    } prio_t;

    function automatic logic [DATA_W-1:0] vec_word(input code_t c);
        return {c, {(DATA_W-CODE_W){1'b0}}};
    endfunction

endpackage

// File: rtl/irqv_src_regs.sv
module irqv_src_regs #(
    parameter int                   NUM_SRC = 32,
    parameter logic [NUM_SRC-1:0]   IMPL    = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= src_req & IMPL;
            if (mask_we) begin
                mask_q <= mask_wdata & IMPL;
            end
        end
    end

endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc
    import irqv_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] active,
    output prio_t              win
);

    logic [NUM_SRC:0]   lower_any;
    code_t              sel_code [NUM_SRC];

    assign lower_any[0] = 1'b0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cascade
        assign lower_any[i+1] = lower_any[i] | active[i];
        assign sel_code[i]    = (active[i] && !lower_any[i]) ? code_t'(i + 1) : '0;
    end

    always_comb begin
        code_t acc;
        acc = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            acc = acc | sel_code[i];
        end
        win.hit  = lower_any[NUM_SRC];
        win.code = acc;
    end

endmodule

// File: rtl/irqv_vector.sv
module irqv_vector
    import irqv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  prio_t win,
    output code_t vec_q
);

    logic req_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q      <= ERR_CODE;
            req_seen_q <= 1'b0;
        end else begin
            req_seen_q <= win.hit;
            if (win.hit) begin
                vec_q <= win.code;
            end else if (req_seen_q) begin
                vec_q <= ERR_CODE;
            end
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int                 NUM_SRC  = 32,
    parameter logic [NUM_SRC-1:0] IMPL_SRC = 32'h7FFF_7BFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] active;
    prio_t              win;
    code_t              vec_code;
    reg_addr_e          ra;

    assign ra = reg_addr_e'(addr);

    irqv_src_regs #(
        .NUM_SRC (NUM_SRC),
        .IMPL    (IMPL_SRC)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .src_req    (src_req),
        .mask_we    (wr_en && ra == RA_MASK),
        .mask_wdata (wdata[NUM_SRC-1:0]),
        .pend_q     (pend_q),
        .mask_q     (mask_q)
    );

    assign active = pend_q & mask_q;
    assign irq_o  = |active;

    irqv_prio_enc #(
        .NUM_SRC (NUM_SRC)
    ) u_enc (
        .active (active),
        .win    (win)
    );

    irqv_vector u_vec (
        .clk   (clk),
        .rst   (rst),
        .win   (win),
        .vec_q (vec_code)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (ra)
                RA_MASK: rdata = DATA_W'(mask_q);
                RA_PEND: rdata = DATA_W'(pend_q);
                RA_VEC:  rdata = vec_word(vec_code);
                RA_NONE: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int                 NUM_SRC = 32,
    parameter logic [NUM_SRC-1:0] IMPL    = '1
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] src_req,
    input logic               wr_en,
    input logic [1:0]         addr,
    input logic [31:0]        wdata,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [7:0]         vec_code
);

    p_mask_wr_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0) |=> (mask_q == ($past(wdata[NUM_SRC-1:0]) & IMPL)));

    p_pend_follow_r3: assert property (@(posedge clk) disable iff (rst)
        !irq_o || irq_o |=> (pend_q == ($past(src_req) & IMPL)));

    p_irq_src_r4: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_q != '0 && mask_q != '0));

    p_irq_vec_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> (vec_code != 8'd0));

    p_race_err_r6: assert property (@(posedge clk) disable iff (rst)
        (!irq_o && $past(irq_o)) |=> (vec_code == 8'd0));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!irq_o && !$past(irq_o)) |=> $stable(vec_code));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .IMPL    (IMPL_SRC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_o    (irq_o),
    .src_req  (src_req),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .mask_q   (mask_q),
    .pend_q   (pend_q),
    .vec_code (vec_code)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;

    localparam int NSRC = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_req = '0;
    logic            rd_en = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      addr = 2'd0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk     (clk),
        .rst     (rst),
        .src_req (src_req),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_o   (irq_o)
    );

    typedef struct packed {
        logic [31:0] req;
        logic [31:0] mask;
        logic        irq;
        logic [7:0]  code;
    } vec_t;

    localparam vec_t TABLE [8] = '{
        '{32'h0000_0020, 32'hFFFF_FFFF, 1'b1, 8'd6},
        '{32'h0010_0008, 32'hFFFF_FFFF, 1'b1, 8'd4},
        '{32'h0010_0008, 32'hFFFF_FFF7, 1'b1, 8'd21},
        '{32'hF000_0000, 32'hFFFF_FFFF, 1'b1, 8'd29},
        '{32'h8000_0001, 32'hFFFF_FFFF, 1'b1, 8'd1},
        '{32'h8000_1400, 32'hFFFF_FFFF, 1'b1, 8'd13},
        '{32'hFFFF_FFFF, 32'h0001_0000, 1'b1, 8'd17},
        '{32'h0003_0000, 32'h0002_0000, 1'b1, 8'd18}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        rd_en = 1'b1;
        addr  = a;
        #1;
        d     = rdata;
        rd_en = 1'b0;
        #1;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        e0;
        logic        e1;

        tick(3);
        rst = 1'b0;

        // R1: reset state
        bus_read(2'd0, rd); check("R1 mask", rd, 32'h0);
        bus_read(2'd1, rd); check("R1 pend", rd, 32'h0);
        bus_read(2'd2, rd); check("R1 vec", rd, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2: reserved mask bits
        bus_write(2'd0, 32'hFFFF_FFFF);
        bus_read(2'd0, rd); check("R2 mask readback", rd, 32'h7FFF_7BFF);

        // R8: writes elsewhere ignored, address 3 and idle bus read zero
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_write(2'd2, 32'hFFFF_FFFF);
        bus_write(2'd3, 32'hFFFF_FFFF);
        bus_read(2'd1, rd); check("R8 pend untouched", rd, 32'h0);
        bus_read(2'd2, rd); check("R8 vec untouched", rd, 32'h0);
        bus_read(2'd3, rd); check("R8 addr3 zero", rd, 32'h0);
        bus_read(2'd0, rd); check("R8 mask untouched", rd, 32'h7FFF_7BFF);
        addr = 2'd0; #1;
        check("R8 rdata idle", rdata, 32'h0);

        // R4 R5: table of request and mask patterns
        for (int k = 0; k < 8; k++) begin
            bus_write(2'd0, TABLE[k].mask);
            src_req = TABLE[k].req;
            tick(3);
            check($sformatf("R4 irq entry %0d", k), {31'b0, irq_o}, {31'b0, TABLE[k].irq});
            bus_read(2'd2, rd);
            check($sformatf("R5 vec entry %0d", k), rd, {TABLE[k].code, 24'h0});
        end

        // R3: reserved sources never pend
        bus_read(2'd1, rd); check("R3 pend pattern", rd, 32'h0003_0000);
        src_req = 32'h8000_8400;
        tick(2);
        bus_read(2'd1, rd); check("R3 reserved pend", rd, 32'h0);

        // R6: mask cleared while the only source drives the request
        src_req = 32'h0000_0020;
        bus_write(2'd0, 32'hFFFF_FFFF);
        tick(3);
        bus_read(2'd2, rd); check("R6 pre vec", rd, {8'd6, 24'h0});
        bus_write(2'd0, 32'h0);
        check("R4 irq after mask clear", {31'b0, irq_o}, 32'h0);
        tick(1);
        bus_read(2'd2, rd); check("R6 error code", rd, 32'h0);

        // R7: hold while idle, masked pending ignored
        tick(3);
        bus_read(2'd2, rd); check("R7 hold", rd, 32'h0);

        // R6: masking one source while another remains unmasked
        src_req = 32'h0000_0220;
        bus_write(2'd0, 32'h0000_0220);
        tick(3);
        bus_read(2'd2, rd); check("R5 two sources", rd, {8'd6, 24'h0});
        bus_write(2'd0, 32'h0000_0200);
        tick(1);
        check("R4 irq stays", {31'b0, irq_o}, 32'h1);
        bus_read(2'd2, rd); check("R6 no error with other", rd, {8'd10, 24'h0});

        // R3: partial event clearing on an aggregating source
        src_req = 32'h0;
        bus_write(2'd0, 32'h0000_0010);
        tick(3);
        e0 = 1'b1; e1 = 1'b1;
        src_req = {27'b0, e0 | e1, 4'b0};
        tick(3);
        bus_read(2'd2, rd); check("R5 source 4", rd, {8'd5, 24'h0});
        e0 = 1'b0;
        src_req = {27'b0, e0 | e1, 4'b0};
        tick(3);
        bus_read(2'd1, rd); check("R3 partial clear pend", rd, 32'h0000_0010);
        check("R3 partial clear irq", {31'b0, irq_o}, 32'h1);
        e1 = 1'b0;
        src_req = {27'b0, e0 | e1, 4'b0};
        tick(1);
        bus_read(2'd1, rd); check("R3 full clear pend", rd, 32'h0);
        check("R3 full clear irq", {31'b0, irq_o}, 32'h0);
        tick(1);
        bus_read(2'd2, rd); check("R6 drop gives error", rd, 32'h0);

        // R7: masked source pending, no request, vector kept
        src_req = 32'h0000_0080;
        tick(3);
        check("R7 masked no irq", {31'b0, irq_o}, 32'h0);
        bus_read(2'd2, rd); check("R7 vec kept", rd, 32'h0);

        // R1: reset in the middle of activity
        bus_write(2'd0, 32'h0000_0080);
        tick(2);
        check("R4 irq before reset", {31'b0, irq_o}, 32'h1);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        bus_read(2'd0, rd); check("R1 mask after reset", rd, 32'h0);
        bus_read(2'd2, rd); check("R1 vec after reset", rd, 32'h0);
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule